// File: doc/BRIEF.md
# Two-Pipe Four-Layer Pixel Compositor

This block composites one output pixel from four overlay layers in two steps. Each layer supplies an enable, a coverage flag for the current pixel, a 2-bit priority, a 1-bit pipe select and a 32-bit ARGB pixel. In the first step, each of the two pipes keeps only the pixel of its highest-priority layer that is enabled and covers the pixel. Nothing is blended inside a pipe.

In the second step, the pipe-0 result is first blended over a programmable background colour. The pipe-1 result is then alpha-blended over that. A defect-emulation input reproduces a hardware fault. With this input set, a priority-0 plane on pipe 0 that carries alpha shows the background instead of its own colour.

Pixels enter and leave on valid/ready streams. The output is registered, with one cycle of latency.

Top module: `layer_mixer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and the background colour register holds black (0x000000).
- R2: Within one pipe, the winning layer is the one with the largest priority value. Its RGB passes through that pipe with no blending against lower layers in the same pipe. Layer i uses bits `[32*i+31:32*i]` of `layer_argb` (alpha in the top byte, then R, G, B), bits `[2*i+1:2*i]` of `layer_prio`, and bit i of `layer_en`, `layer_cov` and `layer_pipe`.
- R3: When two eligible layers on the same pipe have equal priority, the layer with the lower index wins.
- R4: A layer whose enable bit or coverage bit is 0 has no effect on the output.
- R5: The final colour is pipe 1 blended over the pipe-0 result. Each channel is computed as (a*src + (255-a)*dst + 127)/255, with integer division. Alpha 255 gives the source unchanged and alpha 0 gives the destination unchanged.
- R6: A pipe with no eligible layer contributes alpha 0, so the colour below it shows through. A pixel with no eligible layer at all outputs the background colour.
- R7: When `lowest_alpha_bug` is 1, the pipe-0 winner has priority 0 and its alpha is not 255, the pipe-0 result is the background colour. A pipe-0 winner with higher priority, or with alpha 255, is unaffected.
- R8: When `lowest_alpha_bug` is 0, the pipe-0 winner is blended over the background colour with its own alpha, whatever its priority.
- R9: A pixel accepted when `in_valid` and `in_ready` are both 1 appears on `out_rgb`, with `out_valid` set, after the next rising edge.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_rgb` and `out_valid` hold their values and `in_ready` is 0.
- R11: A clock edge with `bg_wr` at 1 loads `bg_data` into the background colour register. All later pixels use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bg_wr | input | 1 | Background colour write strobe |
| bg_data | input | 24 | New background RGB |
| lowest_alpha_bug | input | 1 | Emulate the lowest-plane alpha defect |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Compositor can accept a pixel |
| layer_en | input | 4 | Per-layer enable |
| layer_cov | input | 4 | Per-layer coverage of this pixel |
| layer_prio | input | 8 | Per-layer 2-bit priority |
| layer_pipe | input | 4 | Per-layer pipe select |
| layer_argb | input | 128 | Per-layer ARGB8888 pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can accept |
| out_rgb | output | 24 | Composited RGB |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Priority tie (R3):** two pipe-0 layers share a priority. A design that lets the higher index win shows the wrong colour.
- **Ignored layers (R4):** a high-priority layer is disabled in one test and has coverage 0 in another. A design that skips either gate picks the hidden layer.
- **Blend edges (R5):** alpha 0, 128 and 255 are used, and the rounded results are checked. A truncating or shift-by-8 divider shows up as one count off at mid alpha, or as a darkened colour at alpha 255.
- **Defect input (R7, R8):** the same translucent priority-0 plane is sent with the input set and clear. Priority-1 and opaque planes are also sent to confirm the defect is confined to translucent priority-0 pipe-0 winners.
- **Backpressure (R10):** a second pixel is offered while the output is stalled. A design that overwrites the held pixel or drops the offered one is caught.

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int NL = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bg_wr,
  input  logic [23:0]    bg_data,
  input  logic           lowest_alpha_bug,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [NL-1:0]  layer_en,
  input  logic [NL-1:0]  layer_cov,
  input  logic [2*NL-1:0] layer_prio,
  input  logic [NL-1:0]  layer_pipe,
  input  logic [32*NL-1:0] layer_argb,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [23:0]    out_rgb
);

  logic [23:0] bg_q;
  logic [1:0]  hit;
  logic [1:0]  best_prio [2];
  logic [31:0] best_px [2];
  logic [7:0]  a0, a1;
  logic        bug_hit;
  logic [23:0] base0, mix;

  function automatic logic [7:0] blend8(input logic [7:0] a, input logic [7:0] s, input logic [7:0] d);
    logic [16:0] acc;
    acc = 17'(a) * 17'(s) + 17'(8'd255 - a) * 17'(d) + 17'd127;
    return 8'(acc / 17'd255);
  endfunction

  function automatic logic [23:0] blend24(input logic [7:0] a, input logic [23:0] s, input logic [23:0] d);
    return {blend8(a, s[23:16], d[23:16]), blend8(a, s[15:8], d[15:8]), blend8(a, s[7:0], d[7:0])};
  endfunction

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      hit[p] = 1'b0;
      best_prio[p] = '0;
      best_px[p] = '0;
      for (int i = NL-1; i >= 0; i--) begin
        if (layer_en[i] && layer_cov[i] && (int'(layer_pipe[i]) == p) &&
            (!hit[p] || layer_prio[2*i +: 2] >= best_prio[p])) begin
          hit[p] = 1'b1;
          best_prio[p] = layer_prio[2*i +: 2];
          best_px[p] = layer_argb[32*i +: 32];
        end
      end
    end
  end

  assign a0 = hit[0] ? best_px[0][31:24] : 8'd0;
  assign a1 = hit[1] ? best_px[1][31:24] : 8'd0;
  assign bug_hit = lowest_alpha_bug && hit[0] && (best_prio[0] == 2'd0) && (a0 != 8'hFF);
  assign base0 = bug_hit ? bg_q : blend24(a0, best_px[0][23:0], bg_q);
  assign mix = blend24(a1, best_px[1][23:0], base0);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bg_q <= '0;
      out_valid <= 1'b0;
      out_rgb <= '0;
    end else begin
      if (bg_wr) bg_q <= bg_data;
      if (in_valid && in_ready) begin
        out_valid <= 1'b1;
        out_rgb <= mix;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

module layer_mixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [3:0]  layer_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_rgb,
  input logic [23:0] bg_q
);
  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_empty_shows_bg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && layer_en == 4'd0) |=> (out_rgb == $past(bg_q)));
  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));
endmodule

bind layer_mixer layer_mixer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .layer_en(layer_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_rgb(out_rgb), .bg_q(bg_q)
);

// File: tb/layer_mixer_tb.sv
module layer_mixer_tb_top;
  logic clk = 0, rst_n = 0;
  logic bg_wr = 0, lowest_alpha_bug = 0, in_valid = 0, out_ready = 1;
  logic [23:0] bg_data = '0;
  logic [3:0] layer_en = '0, layer_cov = '0, layer_pipe = '0;
  logic [7:0] layer_prio = '0;
  logic [127:0] layer_argb = '0;
  logic in_ready, out_valid;
  logic [23:0] out_rgb;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  layer_mixer dut_i (.*);

  function automatic logic [7:0] bl8(input int a, input int s, input int d);
    return 8'((a*s + (255-a)*d + 127) / 255);
  endfunction
  function automatic logic [23:0] bl(input int a, input logic [23:0] s, input logic [23:0] d);
    return {bl8(a, s[23:16], d[23:16]), bl8(a, s[15:8], d[15:8]), bl8(a, s[7:0], d[7:0])};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_layers();
    layer_en = '0; layer_cov = '0; layer_pipe = '0; layer_prio = '0; layer_argb = '0;
  endtask

  task automatic set_layer(input int i, input logic [1:0] pr, input logic pp, input logic [31:0] px);
    layer_en[i] = 1; layer_cov[i] = 1; layer_prio[2*i +: 2] = pr;
    layer_pipe[i] = pp; layer_argb[32*i +: 32] = px;
  endtask

  task automatic send(input string req, input logic [23:0] exp);
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {8'd0, out_rgb}, {8'd0, exp});
    @(negedge clk);
  endtask

  task automatic write_bg(input logic [23:0] v);
    bg_wr = 1; bg_data = v;
    @(negedge clk);
    bg_wr = 0;
  endtask

  task automatic t_reset();
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 in_ready", {31'd0, in_ready}, 1);
    clear_layers();
    send("R1 black bg", 24'h000000);
  endtask

  task automatic t_priority();
    clear_layers();
    set_layer(0, 2'd1, 0, 32'hFFFF0000);
    set_layer(1, 2'd3, 0, 32'h8000FF00);
    send("R2 top prio wins, no intra-pipe blend", bl(8'h80, 24'h00FF00, 24'h000000));
    set_layer(1, 2'd3, 0, 32'hFF00FF00);
    send("R2 opaque top", 24'h00FF00);
  endtask

  task automatic t_tie();
    clear_layers();
    set_layer(2, 2'd2, 0, 32'hFF445566);
    set_layer(0, 2'd2, 0, 32'hFF112233);
    send("R3 tie lower index", 24'h112233);
  endtask

  task automatic t_ignored();
    clear_layers();
    set_layer(0, 2'd1, 0, 32'hFF0A0B0C);
    set_layer(1, 2'd3, 0, 32'hFFEEEEEE); layer_en[1] = 0;
    set_layer(2, 2'd3, 0, 32'hFFDDDDDD); layer_cov[2] = 0;
    set_layer(3, 2'd2, 1, 32'hFF999999); layer_en[3] = 0;
    send("R4 disabled/uncovered ignored", 24'h0A0B0C);
  endtask

  task automatic t_blend();
    clear_layers();
    set_layer(0, 2'd0, 0, 32'hFF0000FF);
    set_layer(1, 2'd0, 1, 32'h80FF0000);
    send("R5 mid alpha", bl(128, 24'hFF0000, 24'h0000FF));
    set_layer(1, 2'd0, 1, 32'hFFFF0000);
    send("R5 alpha 255", 24'hFF0000);
    set_layer(1, 2'd0, 1, 32'h00FF0000);
    send("R5 alpha 0", 24'h0000FF);
  endtask

  task automatic t_bg_empty();
    write_bg(24'h204060);
    clear_layers();
    send("R11 bg write", 24'h204060);
    set_layer(2, 2'd1, 1, 32'h80FFFFFF);
    send("R6 empty pipe0", bl(128, 24'hFFFFFF, 24'h204060));
  endtask

  task automatic t_bug();
    clear_layers();
    set_layer(1, 2'd0, 0, 32'h80FFFFFF);
    lowest_alpha_bug = 1;
    send("R7 translucent lowest shows bg", 24'h204060);
    set_layer(1, 2'd0, 0, 32'hFFFFFFFF);
    send("R7 opaque lowest unaffected", 24'hFFFFFF);
    set_layer(1, 2'd1, 0, 32'h80FFFFFF);
    send("R7 prio1 unaffected", bl(128, 24'hFFFFFF, 24'h204060));
    set_layer(1, 2'd0, 0, 32'h80FFFFFF);
    lowest_alpha_bug = 0;
    send("R8 lowest blended", bl(128, 24'hFFFFFF, 24'h204060));
  endtask

  task automatic t_backpressure();
    clear_layers();
    set_layer(0, 2'd0, 0, 32'hFF123456);
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    check("R9 latency", {31'd0, out_valid}, 1);
    check("R9 data", {8'd0, out_rgb}, 32'h123456);
    set_layer(0, 2'd0, 0, 32'hFF654321);
    check("R10 in_ready low", {31'd0, in_ready}, 0);
    @(negedge clk);
    @(negedge clk);
    check("R10 held", {8'd0, out_rgb}, 32'h123456);
    check("R10 valid held", {31'd0, out_valid}, 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R10 next accepted", {8'd0, out_rgb}, 32'h654321);
    @(negedge clk);
    check("R10 drains", {31'd0, out_valid}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priority();
        t_tie();
        t_ignored();
        t_blend();
        t_bg_empty();
        t_bug();
        t_backpressure();
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule